// File: doc/BRIEF.md
# Stepped Rail Voltage Setter

This block programs a supply rail whose level is set by a digital potentiometer reached over an SPI link. The wiper code is a resistance: code 0 is the highest rail voltage, which a fixed series resistor caps, and each larger code lowers the rail. A controller asks for a new operating point by pulsing `req` with a wiper code. The block limits that code to a permitted window and then moves the wiper toward it one code at a time. Each step is its own SPI write, followed by a programmable settle wait, so the rail never jumps by more than one code. The logic clock keeps running through the whole sequence.

At reset release the block first writes code 0, the safe ceiling, and waits one settle period. Requests made during that start-up phase are dropped. After start-up a request is taken in any state. A request made while a walk is running replaces the target, and the next step decision uses the new target, even if that turns the walk around. When the wiper matches the target, `done` pulses for one cycle and `busy` falls.

The controller is a single FSM with seven states:
- ST_INIT_TX sends the start-up frame and moves to ST_INIT_SETTLE when the frame ends.
- ST_INIT_SETTLE moves to ST_IDLE when the settle wait expires.
- ST_IDLE moves to ST_EVAL on a request.
- ST_EVAL moves to ST_DONE when the wiper equals the target. Otherwise it moves the wiper one code and goes to ST_TX.
- ST_TX moves to ST_SETTLE when the frame ends.
- ST_SETTLE returns to ST_EVAL when the wait expires.
- ST_DONE goes to ST_EVAL on a request and to ST_IDLE otherwise.

Top module: `vrail_stepper`

## Requirements
- R1: While reset is held, `spi_cs_n` is 1, `spi_sclk` is 0, `done` is 0 and `busy` is 1. The first frame after release carries wiper code 0.
- R2: A request made before the start-up frame and its settle wait have finished has no effect: no further frame is sent and `busy` falls once start-up ends.
- R3: Every frame is 16 bits long with `spi_cs_n` low for the whole frame. It is sent MSB first in SPI mode 0: the clock idles low and data is valid on the rising edge. Bits 15..8 carry CMD_BYTE and bits 7..0 carry the wiper code.
- R4: A larger wiper code means a higher resistance and a lower rail. Code 0 is the ceiling.
- R5: Each frame changes the wiper by exactly one code toward the target. Every intermediate code is written in order.
- R6: A requested code below CODE_LO is replaced by CODE_LO. A requested code above CODE_HI is replaced by CODE_HI.
- R7: Between the end of one frame and the start of the next, `spi_cs_n` stays high for at least SETTLE_CYC clock cycles.
- R8: A request made during a walk replaces the target from the next step decision on. This includes a reversal of direction.
- R9: When the wiper equals the target, `done` is high for exactly one cycle with `busy` low. A request equal to the current wiper code gives `done` without any frame.
- R10: `busy` is high from the cycle after a request until `done`. Frames are sent only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request strobe |
| target_code | input | CODE_W | Requested wiper code (larger code gives lower rail) |
| busy | output | 1 | Start-up or walk in progress |
| done | output | 1 | One-cycle pulse when the target is reached |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data, MSB first |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The walk is driven with these target patterns:
- An upward move and a downward move. Together they show that the step direction follows the sign of the difference and that every intermediate code appears.
- Targets beyond each edge of the window. These separate correct clamping from a walk that runs off the end.
- A target equal to the present code. This shows that `done` comes without any frame.
- A retarget that reverses the walk partway. This shows that a late request is used at the next step and is not lost.

A request made during start-up is checked to leave the link silent. A CMD_BYTE with mixed bits in the bench shows any byte swap or bit-order error in the decoded frames.

// File: rtl/vrail_pkg.sv
package vrail_pkg;

    typedef enum logic [2:0] {
        ST_INIT_TX,
        ST_INIT_SETTLE,
        ST_IDLE,
        ST_EVAL,
        ST_TX,
        ST_SETTLE,
        ST_DONE
    } vstep_state_e;

endpackage

// File: rtl/vrail_code_clamp.sv
module vrail_code_clamp #(
    parameter int CODE_W  = 8,
    parameter int CODE_LO = 0,
    parameter int CODE_HI = 96
) (
    input  logic [CODE_W-1:0] raw_code,
    output logic [CODE_W-1:0] safe_code
);
    localparam logic [CODE_W-1:0] LO_C = CODE_W'(CODE_LO);
    localparam logic [CODE_W-1:0] HI_C = CODE_W'(CODE_HI);

    always_comb begin
        if (int'(raw_code) < CODE_LO) begin
            safe_code = LO_C;
        end else if (int'(raw_code) > CODE_HI) begin
            safe_code = HI_C;
        end else begin
            safe_code = raw_code;
        end
    end
endmodule

// File: rtl/vrail_settle_timer.sv
module vrail_settle_timer #(
    parameter int SETTLE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vrail_spi_tx.sv
module vrail_spi_tx #(
    parameter int FRAME_W   = 16,
    parameter int SCLK_HALF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_data,
    output logic               ready,
    output logic               frame_done,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n
);
    localparam int DIV_W = $clog2(SCLK_HALF + 1);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    logic               active_q;
    logic               sclk_q;
    logic [DIV_W-1:0]   div_q;
    logic [BIT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               half_end;

    assign half_end   = (div_q == DIV_LAST);
    assign frame_done = active_q && half_end && sclk_q && (bit_q == BIT_LAST);
    assign ready      = !active_q;
    assign sclk       = sclk_q;
    assign cs_n       = !active_q;
    assign mosi       = active_q && shreg_q[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            shreg_q  <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                div_q    <= '0;
                bit_q    <= '0;
                shreg_q  <= frame_data;
            end
        end else if (half_end) begin
            div_q <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (bit_q == BIT_LAST) begin
                    active_q <= 1'b0;
                end else begin
                    bit_q   <= bit_q + 1'b1;
                    shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                end
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/vrail_stepper.sv
module vrail_stepper #(
    parameter int                CODE_W     = 8,
    parameter int                CMD_W      = 8,
    parameter logic [CMD_W-1:0]  CMD_BYTE   = 8'h3C,
    parameter int                CODE_LO    = 0,
    parameter int                CODE_HI    = 96,
    parameter int                SCLK_HALF  = 4,
    parameter int                SETTLE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CODE_W-1:0] target_code,
    output logic              busy,
    output logic              done,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n
);
    import vrail_pkg::*;

    localparam int FRAME_W = CMD_W + CODE_W;

    vstep_state_e      state_q, state_d;
    logic [CODE_W-1:0] cur_code_q;
    logic [CODE_W-1:0] tgt_code_q;
    logic [CODE_W-1:0] clamp_code;
    logic [CODE_W-1:0] eff_tgt;
    logic              in_init;
    logic              accept_req;
    logic              spi_ready;
    logic              spi_start;
    logic              frame_done;
    logic              settle_run;
    logic              settle_expired;

    vrail_code_clamp #(
        .CODE_W (CODE_W),
        .CODE_LO(CODE_LO),
        .CODE_HI(CODE_HI)
    ) clamp_i (
        .raw_code (target_code),
        .safe_code(clamp_code)
    );

    vrail_spi_tx #(
        .FRAME_W  (FRAME_W),
        .SCLK_HALF(SCLK_HALF)
    ) spi_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (spi_start),
        .frame_data({CMD_BYTE, cur_code_q}),
        .ready     (spi_ready),
        .frame_done(frame_done),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .cs_n      (spi_cs_n)
    );

    vrail_settle_timer #(
        .SETTLE_CYC(SETTLE_CYC)
    ) settle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (settle_run),
        .expired(settle_expired)
    );

    assign in_init    = (state_q == ST_INIT_TX) || (state_q == ST_INIT_SETTLE);
    assign accept_req = req && !in_init;
    assign eff_tgt    = accept_req ? clamp_code : tgt_code_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT_TX:     if (frame_done) state_d = ST_INIT_SETTLE;
            ST_INIT_SETTLE: if (settle_expired) state_d = ST_IDLE;
            ST_IDLE:        if (req) state_d = ST_EVAL;
            ST_EVAL:        state_d = (cur_code_q == eff_tgt) ? ST_DONE : ST_TX;
            ST_TX:          if (frame_done) state_d = ST_SETTLE;
            ST_SETTLE:      if (settle_expired) state_d = ST_EVAL;
            ST_DONE:        state_d = req ? ST_EVAL : ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT_TX;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers: target and present wiper code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_code_q <= '0;
            tgt_code_q <= CODE_W'(CODE_LO);
        end else begin
            if (accept_req) begin
                tgt_code_q <= clamp_code;
            end
            if ((state_q == ST_EVAL) && (cur_code_q != eff_tgt)) begin
                if (cur_code_q < eff_tgt) begin
                    cur_code_q <= cur_code_q + 1'b1;
                end else begin
                    cur_code_q <= cur_code_q - 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        spi_start  = 1'b0;
        settle_run = 1'b0;
        unique case (state_q)
            ST_INIT_TX:     spi_start = spi_ready;
            ST_INIT_SETTLE: settle_run = 1'b1;
            ST_IDLE:        busy = 1'b0;
            ST_EVAL:        busy = 1'b1;
            ST_TX:          spi_start = spi_ready;
            ST_SETTLE:      settle_run = 1'b1;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default:        busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/vrail_stepper_chk.sv
module vrail_stepper_chk #(
    parameter int CODE_W  = 8,
    parameter int CODE_LO = 0,
    parameter int CODE_HI = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic [CODE_W-1:0] cur_code,
    input logic [CODE_W-1:0] tgt_code
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sclk); // R3
    AST_FRAME_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !spi_cs_n |-> busy); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cur_code) |-> ((cur_code == $past(cur_code) + 1'b1) || (cur_code == $past(cur_code) - 1'b1))); // R5
    AST_TARGET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (int'(tgt_code) >= CODE_LO) && (int'(tgt_code) <= CODE_HI)); // R6
endmodule

bind vrail_stepper vrail_stepper_chk #(
    .CODE_W (CODE_W),
    .CODE_LO(CODE_LO),
    .CODE_HI(CODE_HI)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n),
    .cur_code(cur_code_q),
    .tgt_code(tgt_code_q)
);

// File: tb/vrail_stepper_tb_top.sv
module vrail_stepper_tb_top;
    localparam int         CODE_W = 8;
    localparam logic [7:0] CMD    = 8'hA5;
    localparam int         LO     = 2;
    localparam int         HI     = 12;
    localparam int         SETTLE = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [CODE_W-1:0] target_code = '0;
    logic              busy, done, spi_sclk, spi_mosi, spi_cs_n;

    int n_chk = 0;
    int n_err = 0;
    int model_cur = 0;

    // frame monitor
    logic [15:0] frames [0:63];
    int          frame_cnt = 0;
    int          bad_len = 0;
    int          mon_bits = 0;
    logic [15:0] mon_sh = '0;
    int          hi_cnt = 0;
    int          gap_min = 1000000;

    always #10 clk = ~clk;

    vrail_stepper #(
        .CODE_W    (CODE_W),
        .CMD_W     (8),
        .CMD_BYTE  (CMD),
        .CODE_LO   (LO),
        .CODE_HI   (HI),
        .SCLK_HALF (2),
        .SETTLE_CYC(SETTLE)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .target_code(target_code),
        .busy       (busy),
        .done       (done),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_cs_n   (spi_cs_n)
    );

    always @(negedge spi_cs_n) begin
        mon_bits = 0;
        mon_sh   = '0;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            mon_sh   = {mon_sh[14:0], spi_mosi};
            mon_bits = mon_bits + 1;
        end
    end

    always @(posedge spi_cs_n) begin
        if (mon_bits != 0) begin
            if (mon_bits != 16) bad_len = bad_len + 1;
            if (frame_cnt < 64) frames[frame_cnt] = mon_sh;
            frame_cnt = frame_cnt + 1;
            mon_bits  = 0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (spi_cs_n) begin
                hi_cnt = hi_cnt + 1;
            end else begin
                if (hi_cnt != 0 && frame_cnt > 0 && hi_cnt < gap_min) gap_min = hi_cnt;
                hi_cnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic pulse_req(input int code);
        @(negedge clk);
        req = 1'b1;
        target_code = CODE_W'(code);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 5000; i++) begin
            if (frame_cnt >= n) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_init();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state held during reset
        check(spi_cs_n == 1'b1, "R1 cs_n in reset", int'(spi_cs_n), 1);
        check(spi_sclk == 1'b0, "R1 sclk in reset", int'(spi_sclk), 0);
        check(done == 1'b0 && busy == 1'b1, "R1 done/busy in reset", int'({busy, done}), 2);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R2: request during start-up must be dropped
        pulse_req(7);
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check(frame_cnt == 1, "R1 start-up frame count", frame_cnt, 1);
        check(frames[0] == {CMD, 8'h00}, "R1 start-up frame writes code 0", int'(frames[0]), int'({CMD, 8'h00}));
        repeat (300) @(negedge clk);
        check(frame_cnt == 1, "R2 start-up request ignored (frames)", frame_cnt, 1);
        check(busy == 1'b0, "R2 start-up request ignored (busy)", int'(busy), 0);
        model_cur = 0;
    endtask

    task automatic t_move(input int req_code, input int exp_final, input string rq);
        int  base;
        int  steps;
        int  dir;
        bit  seen;
        base  = frame_cnt;
        steps = (exp_final > model_cur) ? exp_final - model_cur : model_cur - exp_final;
        dir   = (exp_final > model_cur) ? 1 : -1;
        pulse_req(req_code);
        check(busy == 1'b1, {rq, " R10 busy after request"}, int'(busy), 1);
        wait_done(seen);
        check(seen, {rq, " R9 done reached"}, int'(seen), 1);
        check(busy == 1'b0, {rq, " R9 busy low with done"}, int'(busy), 0);
        check(frame_cnt - base == steps, {rq, " R5 frame count"}, frame_cnt - base, steps);
        for (int k = 0; k < steps; k++) begin
            check(frames[base + k] == {CMD, 8'(model_cur + dir * (k + 1))},
                  {rq, " R3/R5 frame content"}, int'(frames[base + k]),
                  int'({CMD, 8'(model_cur + dir * (k + 1))}));
        end
        @(negedge clk);
        check(done == 1'b0, {rq, " R9 done one cycle"}, int'(done), 0);
        model_cur = exp_final;
    endtask

    task automatic t_retarget();
        int  base;
        bit  seen;
        base = frame_cnt;
        pulse_req(9);
        wait_frames(base + 2);
        // R8: reverse direction partway through the walk
        pulse_req(3);
        wait_done(seen);
        check(seen, "R8 done after retarget", int'(seen), 1);
        check(frame_cnt - base == 3, "R8 frame count after reversal", frame_cnt - base, 3);
        check(frames[base] == {CMD, 8'd3}, "R8 first step", int'(frames[base]), int'({CMD, 8'd3}));
        check(frames[base + 1] == {CMD, 8'd4}, "R8 second step", int'(frames[base + 1]), int'({CMD, 8'd4}));
        check(frames[base + 2] == {CMD, 8'd3}, "R8 reversed step", int'(frames[base + 2]), int'({CMD, 8'd3}));
        model_cur = 3;
    endtask

    initial begin
        t_reset_init();
        t_move(5, 5, "up R4");
        t_move(3, 3, "down R4");
        t_move(200, HI, "clamp high R6");
        t_move(0, LO, "clamp low R6");
        t_move(LO, LO, "equal target R9");
        t_retarget();
        check(bad_len == 0, "R3 frame length 16", bad_len, 0);
        check(gap_min >= SETTLE, "R7 settle gap", gap_min, SETTLE);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule